// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Unit

This unit lets any processing element (PE) of a multi-core cluster raise a level-sensitive interrupt on any other PE, across several independent channels. Each PE owns, per channel, a request register (one bit per destination PE) and an enable register (one bit per source PE). A receiver sees a flag for every source that has an enabled request pending towards it. It also receives one interrupt line per channel that stays high while any such flag is set. Either side may withdraw a request: the receiver through its flag-clear register, the sender through its request-clear register. Both clear registers are write-one-to-clear and read as zero.

Software reaches the registers through a simple single-cycle register bus that carries a master ID. Each channel has one bank of registers per PE, addressed directly, plus a virtual self bank. The self bank redirects each access to the bank of the PE whose master ID issued it, so all PEs can run identical code. The word address is laid out as `{channel, bank, register}`: bits [2:0] select the register (0 enable, 1 flag, 2 flag-clear, 3 request, 4 request-clear), bits [5:3] select the bank (0..NUM_PE-1 direct, NUM_PE self), and the bits above select the channel. Master IDs 0..NUM_PE-1 are PEs; any other ID is a non-PE master.

A small response state machine answers every bus request exactly one cycle later. Its states are RSP_IDLE (no response this cycle), RSP_DONE (valid response with read data) and RSP_FAULT (valid response, error set, data zero). Every cycle it moves to RSP_FAULT when a request was refused, to RSP_DONE when a request was accepted, and to RSP_IDLE when no request was presented.

Top module: `ipi_unit`

## Requirements
- R1: There are NUM_CH (default 4) channels. Registers and interrupt lines of one channel are not changed by accesses to another channel.
- R2: Interrupt line irq[c*NUM_PE+m] is high exactly while PE m has at least one flag bit set on channel c. It stays high over idle cycles, with no edge capture.
- R3: Writing the request register (register 3) of PE m loads it. Bit k set means PE m requests an interrupt on PE k, including k = m. A read returns the stored value.
- R4: Bit x of PE m's enable register (register 0) gates source x. A pending request from a disabled source raises no flag and no interrupt, stays stored, and shows up as soon as the bit is enabled.
- R5: Bit x of PE m's flag register (register 1) reads as request bit m of PE x ANDed with enable bit x of PE m. Writes to the flag register have no effect.
- R6: Writing 1 to bit x of PE m's flag-clear register (register 2) clears request bit m of PE x. Zero bits change nothing, and the register reads as 0.
- R7: Writing 1 to bit k of PE m's request-clear register (register 4) clears request bit k of PE m. Zero bits change nothing, and the register reads as 0.
- R8: Bank NUM_PE (value 4 by default) is routed to the bank of the PE given by the master ID. Direct banks 0..NUM_PE-1 are reachable from any master ID.
- R9: A self-bank access by a non-PE master ID (ID >= NUM_PE) returns data 0 with the error flag set, and a write is ignored.
- R10: Every accepted or refused request gets rsp_valid exactly one cycle later, and an idle cycle yields no response. A register select above 4 or a bank above NUM_PE is refused like R9.
- R11: After reset all registers are 0, all interrupt lines are low and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {channel, bank, register} |
| req_wdata | input | DATA_W | Write data; low NUM_PE bits used |
| req_mid | input | MID_W | Master ID of the requester |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and refused accesses |
| rsp_err | output | 1 | Access refused |
| irq | output | NUM_CH*NUM_PE | Level interrupt per channel and PE, index c*NUM_PE+m |

## Verification
A write updates its register at the clock edge that accepts the request. The interrupt lines are combinational from the registers, so they change in the same cycle in which the write's response appears. The response (valid, data, error) is registered once and is due exactly one cycle after the request. The bench drives each request on a falling edge, lets one rising edge pass, and samples the response and the interrupt lines on the next falling edge. Each read of a register value is issued as a separate request after the write that changed it. Extra idle cycles show that the levels hold and that no stray response appears.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int REG_W = 3;

    typedef enum logic [REG_W-1:0] {
        REG_EN   = 3'd0,
        REG_FLG  = 3'd1,
        REG_FCLR = 3'd2,
        REG_REQ  = 3'd3,
        REG_RCLR = 3'd4
    } ipi_reg_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int NUM_CH = 4,
    parameter int MID_W  = 4,
    localparam int PE_W   = $clog2(NUM_PE),
    localparam int BANK_W = $clog2(NUM_PE + 1),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = REG_W + BANK_W + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MID_W-1:0]  mid,
    output logic              bad,
    output logic [CH_W-1:0]   ch,
    output logic [PE_W-1:0]   tgt,
    output ipi_reg_e          regsel
);

    logic [REG_W-1:0]  reg_raw;
    logic [BANK_W-1:0] bank;
    logic              ch_ok;
    logic              reg_ok;

    assign reg_raw = addr[REG_W-1:0];
    assign bank    = addr[REG_W +: BANK_W];
    assign ch      = addr[REG_W+BANK_W +: CH_W];
    assign regsel  = ipi_reg_e'(reg_raw);
    assign reg_ok  = (reg_raw <= REG_W'(REG_RCLR));

    generate
        if ((2 ** CH_W) == NUM_CH) begin : g_ch_full
            assign ch_ok = 1'b1;
        end else begin : g_ch_part
            assign ch_ok = ({1'b0, ch} < (CH_W+1)'(NUM_CH));
        end
    endgenerate

    always_comb begin
        tgt = '0;
        bad = 1'b0;
        if (bank == BANK_W'(NUM_PE)) begin
            // self window: follow the caller's master ID
            if (mid < MID_W'(NUM_PE)) begin
                tgt = mid[PE_W-1:0];
            end else begin
                bad = 1'b1;
            end
        end else if (bank < BANK_W'(NUM_PE)) begin
            tgt = bank[PE_W-1:0];
        end else begin
            bad = 1'b1;
        end
        if (!reg_ok || !ch_ok) begin
            bad = 1'b1;
        end
    end

endmodule

// File: rtl/ipi_channel.sv
module ipi_channel
    import ipi_pkg::*;
#(
    parameter int NUM_PE = 4,
    localparam int PE_W  = $clog2(NUM_PE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [PE_W-1:0]               tgt,
    input  ipi_reg_e                      regsel,
    input  logic [NUM_PE-1:0]             wdata,
    output logic [NUM_PE-1:0][NUM_PE-1:0] en_q,
    output logic [NUM_PE-1:0][NUM_PE-1:0] req_q,
    output logic [NUM_PE-1:0][NUM_PE-1:0] flg,
    output logic [NUM_PE-1:0]             irq
);

    logic [NUM_PE-1:0][NUM_PE-1:0] en_d;
    logic [NUM_PE-1:0][NUM_PE-1:0] req_d;

    always_comb begin
        en_d  = en_q;
        req_d = req_q;
        for (int p = 0; p < NUM_PE; p++) begin
            if (wr && regsel == REG_EN && tgt == PE_W'(p)) begin
                en_d[p] = wdata;
            end
            for (int k = 0; k < NUM_PE; k++) begin
                if (wr && regsel == REG_REQ && tgt == PE_W'(p)) begin
                    req_d[p][k] = wdata[k];
                end
                // receiver-side clear: PE k drops source p's request to k
                if (wr && regsel == REG_FCLR && tgt == PE_W'(k) && wdata[p]) begin
                    req_d[p][k] = 1'b0;
                end
                // sender-side clear: PE p withdraws its request to k
                if (wr && regsel == REG_RCLR && tgt == PE_W'(p) && wdata[k]) begin
                    req_d[p][k] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            req_q <= '0;
        end else begin
            en_q  <= en_d;
            req_q <= req_d;
        end
    end

    always_comb begin
        for (int m = 0; m < NUM_PE; m++) begin
            for (int x = 0; x < NUM_PE; x++) begin
                flg[m][x] = req_q[x][m] & en_q[m][x];
            end
            irq[m] = |flg[m];
        end
    end

    // R2: with no write the interrupt levels hold
    a_r2_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(irq));

    // R4: an enable write lands in the addressed PE's enable register
    a_r4_en_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && regsel == REG_EN) |=> (en_q[$past(tgt)] == $past(wdata)));

    // R5: a flag write leaves requests and enables untouched
    a_r5_flg_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && regsel == REG_FLG) |=> ($stable(req_q) && $stable(en_q)));

    generate
        for (genvar p = 0; p < NUM_PE; p++) begin : g_chk_p
            for (genvar k = 0; k < NUM_PE; k++) begin : g_chk_k
                // R6: receiver clear drops the sender's bit
                a_r6_fclr_drop: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr && regsel == REG_FCLR && tgt == PE_W'(k) && wdata[p])
                    |=> !req_q[p][k]);
                // R7: sender clear drops its own bit
                a_r7_rclr_drop: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr && regsel == REG_RCLR && tgt == PE_W'(p) && wdata[k])
                    |=> !req_q[p][k]);
            end
        end
    endgenerate

endmodule

// File: rtl/ipi_resp.sv
module ipi_resp
    import ipi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              bad,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        unique case (state_q)
            RSP_IDLE, RSP_DONE, RSP_FAULT: begin
                if (!req_valid) begin
                    state_d = RSP_IDLE;
                end else if (bad) begin
                    state_d = RSP_FAULT;
                end else begin
                    state_d = RSP_DONE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (req_valid && !bad) ? rd_data : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = data_q;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // R10: one response per request, exactly one cycle later
    a_r10_resp_due: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r10_refused_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad) |=> rsp_err);

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int NUM_CH = 4,
    parameter int MID_W  = 4,
    parameter int DATA_W = 32,
    localparam int PE_W   = $clog2(NUM_PE),
    localparam int BANK_W = $clog2(NUM_PE + 1),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = REG_W + BANK_W + CH_W,
    localparam int IRQ_W  = NUM_CH * NUM_PE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MID_W-1:0]  req_mid,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [IRQ_W-1:0]  irq
);

    logic              bad;
    logic [CH_W-1:0]   ch;
    logic [PE_W-1:0]   tgt;
    ipi_reg_e          regsel;
    logic [DATA_W-1:0] rd_data;
    logic              unused_hi;

    logic [NUM_PE-1:0][NUM_PE-1:0] en_all  [NUM_CH];
    logic [NUM_PE-1:0][NUM_PE-1:0] req_all [NUM_CH];
    logic [NUM_PE-1:0][NUM_PE-1:0] flg_all [NUM_CH];

    assign unused_hi = ^req_wdata[DATA_W-1:NUM_PE];

    ipi_decode #(
        .NUM_PE (NUM_PE),
        .NUM_CH (NUM_CH),
        .MID_W  (MID_W)
    ) u_decode (
        .addr   (req_addr),
        .mid    (req_mid),
        .bad    (bad),
        .ch     (ch),
        .tgt    (tgt),
        .regsel (regsel)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic wr_c;
            assign wr_c = req_valid && req_write && !bad && (ch == CH_W'(c));
            ipi_channel #(
                .NUM_PE (NUM_PE)
            ) u_channel (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (wr_c),
                .tgt    (tgt),
                .regsel (regsel),
                .wdata  (req_wdata[NUM_PE-1:0]),
                .en_q   (en_all[c]),
                .req_q  (req_all[c]),
                .flg    (flg_all[c]),
                .irq    (irq[c*NUM_PE +: NUM_PE])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (req_valid && !req_write && !bad) begin
            unique case (regsel)
                REG_EN:  rd_data = DATA_W'(en_all[ch][tgt]);
                REG_FLG: rd_data = DATA_W'(flg_all[ch][tgt]);
                REG_REQ: rd_data = DATA_W'(req_all[ch][tgt]);
                default: rd_data = '0;
            endcase
        end
    end

    ipi_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bad       (bad),
        .rd_data   (rd_data),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    // R9: a non-PE master in the self bank gets an error with zero data
    a_r9_self_nonpe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[REG_W +: BANK_W] == BANK_W'(NUM_PE)
         && req_mid >= MID_W'(NUM_PE))
        |=> (rsp_err && rsp_rdata == '0));

    // R1: a write to one channel leaves the other channels' lines alone
    a_r1_ch_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !bad)
        |=> ((irq & ~(IRQ_W'({NUM_PE{1'b1}}) << ($past(ch) * NUM_PE)))
             == ($past(irq) & ~(IRQ_W'({NUM_PE{1'b1}}) << ($past(ch) * NUM_PE)))));

endmodule

// File: tb/tb_ipi_unit.sv
module tb_ipi_unit;

    localparam int NUM_PE = 4;
    localparam int NUM_CH = 4;
    localparam int MID_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IRQ_W  = NUM_CH * NUM_PE;

    // vector: {wr, ch[1:0], bank[2:0], reg[2:0], mid[3:0], wdata[7:0], exp_rd[7:0], exp_err}
    localparam int NV = 15;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'd0, 3'd0, 3'd0, 4'd0, 8'h02, 8'h00, 1'b0}, // PE0 enables source 1
        {1'b1, 2'd0, 3'd1, 3'd3, 4'd1, 8'h01, 8'h00, 1'b0}, // PE1 requests PE0
        {1'b0, 2'd0, 3'd0, 3'd1, 4'd2, 8'h00, 8'h02, 1'b0}, // R5 flag seen directly
        {1'b0, 2'd0, 3'd4, 3'd1, 4'd0, 8'h00, 8'h02, 1'b0}, // R8 flag via self bank
        {1'b1, 2'd0, 3'd2, 3'd3, 4'd2, 8'h01, 8'h00, 1'b0}, // PE2 requests PE0 (masked)
        {1'b0, 2'd0, 3'd0, 3'd1, 4'd0, 8'h00, 8'h02, 1'b0}, // R4 source 2 masked
        {1'b1, 2'd0, 3'd4, 3'd2, 4'd0, 8'h02, 8'h00, 1'b0}, // R6 PE0 clears source 1
        {1'b0, 2'd0, 3'd1, 3'd3, 4'd0, 8'h00, 8'h00, 1'b0}, // R6 PE1 request gone
        {1'b0, 2'd0, 3'd2, 3'd3, 4'd0, 8'h00, 8'h01, 1'b0}, // R4 masked request kept
        {1'b0, 2'd0, 3'd0, 3'd2, 4'd0, 8'h00, 8'h00, 1'b0}, // R6 clear reads zero
        {1'b1, 2'd0, 3'd4, 3'd4, 4'd2, 8'h01, 8'h00, 1'b0}, // R7 PE2 withdraws
        {1'b0, 2'd0, 3'd2, 3'd3, 4'd0, 8'h00, 8'h00, 1'b0}, // R7 request gone
        {1'b0, 2'd0, 3'd4, 3'd0, 4'd9, 8'h00, 8'h00, 1'b1}, // R9 non-PE self read
        {1'b1, 2'd0, 3'd4, 3'd0, 4'd9, 8'h0F, 8'h00, 1'b1}, // R9 non-PE self write
        {1'b0, 2'd0, 3'd0, 3'd0, 4'd0, 8'h00, 8'h02, 1'b0}  // R9 write was ignored
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [MID_W-1:0]  req_mid = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_err;
    logic [IRQ_W-1:0]  irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ipi_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mid   (req_mid),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, sample the response on the next falling edge
    task automatic access(input bit wr, input int ch, input int bank, input int rsel,
                          input int mid, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er, output logic vld);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {ch[1:0], bank[2:0], rsel[2:0]};
        req_wdata = wd;
        req_mid   = mid[3:0];
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        rd  = rsp_rdata;
        er  = rsp_err;
        vld = rsp_valid;
    endtask

    task automatic wr_reg(input int ch, input int bank, input int rsel, input int mid,
                          input logic [31:0] wd);
        logic [31:0] rd;
        logic er, vld;
        access(1'b1, ch, bank, rsel, mid, wd, rd, er, vld);
    endtask

    task automatic rd_chk(input string tag, input int ch, input int bank, input int rsel,
                          input int mid, input logic [31:0] exp);
        logic [31:0] rd;
        logic er, vld;
        access(1'b0, ch, bank, rsel, mid, 32'h0, rd, er, vld);
        check(tag, rd, exp);
    endtask

    initial begin
        int wd_cnt = 0;
        while (!done && wd_cnt < 200000) begin
            @(posedge clk);
            wd_cnt++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", wd_cnt, 200000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er, vld;

        repeat (3) @(negedge clk);
        check("R11 irq in reset", 32'(irq), 32'h0);
        check("R11 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        rd_chk("R11 request reg after reset", 3, 2, 3, 0, 32'h0);
        rd_chk("R11 enable reg after reset", 1, 0, 0, 0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            access(v[29], int'(v[28:27]), int'(v[26:24]), int'(v[23:21]), int'(v[20:17]),
                   {24'h0, v[16:9]}, rd, er, vld);
            check($sformatf("vector %0d rdata", i), rd, {24'h0, v[8:1]});
            check($sformatf("vector %0d err", i), 32'(er), 32'(v[0]));
            check($sformatf("vector %0d R10 rsp_valid", i), 32'(vld), 32'h1);
        end

        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10 no response when idle", 32'(rsp_valid), 32'h0);

        // R2 / R1: channel 1, PE0 -> PE3
        wr_reg(1, 3, 0, 3, 32'h1);
        wr_reg(1, 0, 3, 0, 32'h8);
        check("R2 irq ch1 PE3 raised", 32'(irq), 32'h0080);
        repeat (5) @(negedge clk);
        check("R2 level holds over idle", 32'(irq), 32'h0080);
        rd_chk("R1 ch0 PE3 enable untouched", 0, 3, 0, 0, 32'h0);
        rd_chk("R1 ch1 PE0 enable untouched", 1, 0, 0, 0, 32'h0);

        // R5: flag write ignored
        wr_reg(1, 3, 1, 3, 32'h0);
        rd_chk("R5 flag after write", 1, 3, 1, 3, 32'h1);
        check("R5 irq after flag write", 32'(irq), 32'h0080);

        // R6: zero bits of flag clear change nothing
        wr_reg(1, 4, 2, 3, 32'h6);
        rd_chk("R6 zero bits keep request", 1, 0, 3, 0, 32'h8);
        check("R6 irq after zero-bit clear", 32'(irq), 32'h0080);

        // R4: disabling masks, re-enabling shows the kept request
        wr_reg(1, 3, 0, 3, 32'h0);
        check("R4 irq masked", 32'(irq), 32'h0);
        rd_chk("R4 request kept while masked", 1, 0, 3, 1, 32'h8);
        wr_reg(1, 3, 0, 3, 32'h1);
        check("R4 irq after re-enable", 32'(irq), 32'h0080);

        // R7: zero bits then sender withdraw
        wr_reg(1, 4, 4, 0, 32'h7);
        check("R7 zero bits keep irq", 32'(irq), 32'h0080);
        wr_reg(1, 4, 4, 0, 32'h8);
        check("R7 irq dropped", 32'(irq), 32'h0);
        rd_chk("R7 request cleared", 1, 0, 3, 0, 32'h0);
        rd_chk("R7 clear reads zero", 1, 0, 4, 0, 32'h0);

        // R3: self-request on channel 2 by PE2
        wr_reg(2, 4, 3, 2, 32'h4);
        rd_chk("R3 request readback", 2, 2, 3, 1, 32'h4);
        check("R3 no irq before enable", 32'(irq), 32'h0);
        wr_reg(2, 4, 0, 2, 32'h4);
        check("R3 self irq ch2 PE2", 32'(irq), 32'h0400);
        wr_reg(2, 4, 2, 2, 32'h4);
        check("R6 self flag clear", 32'(irq), 32'h0);

        // R10: unmapped register and bank
        access(1'b0, 0, 0, 5, 0, 32'h0, rd, er, vld);
        check("R10 bad register err", 32'(er), 32'h1);
        check("R10 bad register data", rd, 32'h0);
        access(1'b1, 0, 6, 0, 0, 32'hF, rd, er, vld);
        check("R10 bad bank err", 32'(er), 32'h1);
        check("R10 bad bank valid", 32'(vld), 32'h1);
        rd_chk("R10 bad bank write ignored", 0, 0, 0, 0, 32'h2);

        // R8: direct bank reachable from a non-PE master
        access(1'b0, 0, 0, 0, 9, 32'h0, rd, er, vld);
        check("R8 direct read data", rd, 32'h2);
        check("R8 direct read no err", 32'(er), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule